// File: doc/BRIEF.md
# Gated-Clear Transparent Latch Bank

This block is a bank of level-sensitive data latches, five bits wide by default. All bits share one enable and one clear. The enable comes from two clock inputs combined with a logical OR. While both clock inputs are low, the bank is transparent and every output follows its own data input. When either clock input goes high, the bank closes and keeps the values that were present at that moment.

The clear input is gated by the combined clock. It forces every stored bit low only while the bank is closed. While the bank is transparent, the clear input has no effect.

The block suits places where a wide value must be frozen by either of two independent sources. One example is a capture point that a local strobe and a global freeze can both close. The clear lets the frozen value be wiped without opening the latch.

Top module: `gated_clear_latch_bank`

## Requirements
- R1: The bank holds WIDTH bits (default 5). Each output bit depends only on its own data bit and on the shared clock and clear inputs.
- R2: The bank is closed when clkA or clkB, or both, is 1. It is transparent only when both are 0.
- R3: While transparent, qOut equals dIn, and it follows every change of dIn without needing an edge.
- R4: When the combined clock rises, qOut keeps the dIn value that was present just before the rise.
- R5: While closed with clrReq at 0, changes on dIn leave qOut unchanged.
- R6: While closed with clrReq at 1, every bit of qOut is 0. This holds whether clkA, clkB or both keep the bank closed.
- R7: While transparent, clrReq has no effect, and qOut keeps following dIn.
- R8: The clear acts on the level of clrReq, not on an edge. After clrReq returns to 0 while the bank stays closed, qOut stays all zeros until the bank opens.
- R9: While one clock input is held at 1, toggling the other clock input does not disturb the held value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dIn | input | WIDTH | Data to be passed or held |
| clkA | input | 1 | First clock input; 1 closes the bank |
| clkB | input | 1 | Second clock input; 1 closes the bank |
| clrReq | input | 1 | Clear request; honoured only while the bank is closed |
| qOut | output | WIDTH | Latched data |

## Verification
Hold and clear can coincide: clrReq may rise while the bank is closed and holding a nonzero value. Pass-through and clear can also coincide: clrReq may be high while the bank is open. The vector table provokes both overlaps. It raises clrReq under each clock input alone and under both together, and it sets clrReq during transparency while dIn keeps changing. Each overlap is judged at the outputs. Closed plus clear must give all zeros, and that zero must persist after clrReq drops. Open plus clear must give the data input unchanged.

// File: rtl/gcl_pkg.sv
package gcl_pkg;
  // Strobes from the control decode to the storage bits.
  typedef struct packed {
    logic passEn;   // bank transparent
    logic clearEn;  // bank closed and clear requested
  } latchCtrl_t;
endpackage

// File: rtl/gcl_ctrl.sv
module gcl_ctrl
  import gcl_pkg::*;
(
  input  logic       clkA,
  input  logic       clkB,
  input  logic       clrReq,
  output latchCtrl_t ctrlBus
);
  logic clkHi;

  assign clkHi           = clkA | clkB;
  assign ctrlBus.passEn  = ~clkHi;
  assign ctrlBus.clearEn = clkHi & clrReq;
endmodule

// File: rtl/gcl_datapath.sv
module gcl_datapath
  import gcl_pkg::*;
#(
  parameter int WIDTH = 5
) (
  input  latchCtrl_t       ctrlBus,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] qOut
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic bitQ;
    always_latch begin
      if (ctrlBus.clearEn)     bitQ = 1'b0;
      else if (ctrlBus.passEn) bitQ = dIn[i];
    end
    assign qOut[i] = bitQ;
  end
endmodule

// File: rtl/gated_clear_latch_bank.sv
module gated_clear_latch_bank
  import gcl_pkg::*;
#(
  parameter int WIDTH = 5
) (
  input  logic [WIDTH-1:0] dIn,
  input  logic             clkA,
  input  logic             clkB,
  input  logic             clrReq,
  output logic [WIDTH-1:0] qOut
);
  latchCtrl_t ctrlBus;

  gcl_ctrl u_ctrl (
    .clkA    (clkA),
    .clkB    (clkB),
    .clrReq  (clrReq),
    .ctrlBus (ctrlBus)
  );

  gcl_datapath #(.WIDTH(WIDTH)) u_dp (
    .ctrlBus (ctrlBus),
    .dIn     (dIn),
    .qOut    (qOut)
  );
endmodule

// File: rtl/gcl_checker.sv
module gcl_checker #(
  parameter int WIDTH = 5
) (
  input logic [WIDTH-1:0] dIn,
  input logic             clkA,
  input logic             clkB,
  input logic             clrReq,
  input logic [WIDTH-1:0] qOut
);
  logic             closed;
  logic             clrSeen = 1'b0;
  logic [WIDTH-1:0] capD    = '0;
  logic [WIDTH-1:0] capQ    = '0;

  assign closed = clkA | clkB;

  // Records whether a clear has been requested since the bank last closed.
  always_ff @(posedge closed or posedge clrReq) begin
    if (clrReq) clrSeen <= 1'b1;
    else        clrSeen <= 1'b0;
  end

  always_ff @(posedge closed) begin
    capD <= dIn;
    capQ <= qOut;
  end

  // R3 / R7: just before the bank closes, the output mirrors the input.
  p_follow_r3: assert property (@(posedge closed) disable iff (clrReq)
    qOut == dIn);

  // R4: a clean hold ends with the value present at the rising edge.
  p_capture_r4: assert property (@(negedge closed) disable iff (clrReq)
    !clrSeen |-> qOut == capD);

  // R5 / R9: a clean hold period leaves the output untouched.
  p_hold_r5: assert property (@(negedge closed) disable iff (clrReq)
    !clrSeen |-> qOut == capQ);

  // R6 / R8: a clear during the hold leaves zeros until the bank opens.
  p_clear_r8: assert property (@(negedge closed) disable iff (clrReq)
    clrSeen |-> qOut == '0);
endmodule

bind gated_clear_latch_bank gcl_checker #(.WIDTH(WIDTH)) u_chk (
  .dIn    (dIn),
  .clkA   (clkA),
  .clkB   (clkB),
  .clrReq (clrReq),
  .qOut   (qOut)
);

// File: tb/tb_gated_clear_latch_bank.sv
module tb_gated_clear_latch_bank;
  localparam int W = 5;
  localparam int NVEC = 19;

  logic         clk = 1'b0;
  logic [W-1:0] dIn = '0;
  logic         clkA = 1'b0, clkB = 1'b0, clrReq = 1'b0;
  logic [W-1:0] qOut;
  int           vecCnt = 0;
  int           missCnt = 0;

  always #2.5 clk = ~clk;

  gated_clear_latch_bank #(.WIDTH(W)) dut (
    .dIn(dIn), .clkA(clkA), .clkB(clkB), .clrReq(clrReq), .qOut(qOut)
  );

  // Vector fields: {data[4:0], clkA, clkB, clrReq, expected[4:0]}
  localparam logic [12:0] VEC [NVEC] = '{
    {5'b10110, 3'b000, 5'b10110},  // R3
    {5'b01001, 3'b000, 5'b01001},  // R3
    {5'b01001, 3'b100, 5'b01001},  // R4 close via clkA
    {5'b11111, 3'b100, 5'b01001},  // R5
    {5'b00000, 3'b100, 5'b01001},  // R5
    {5'b00000, 3'b110, 5'b01001},  // R9
    {5'b00000, 3'b010, 5'b01001},  // R9 / R2 clkB alone
    {5'b00000, 3'b011, 5'b00000},  // R6 via clkB
    {5'b00000, 3'b010, 5'b00000},  // R8
    {5'b11010, 3'b010, 5'b00000},  // R5 after clear
    {5'b11010, 3'b000, 5'b11010},  // R3 reopen
    {5'b11010, 3'b001, 5'b11010},  // R7
    {5'b00111, 3'b001, 5'b00111},  // R7 follows under clear
    {5'b00111, 3'b000, 5'b00111},  // R3
    {5'b00111, 3'b100, 5'b00111},  // R4
    {5'b00111, 3'b101, 5'b00000},  // R6 via clkA
    {5'b00111, 3'b111, 5'b00000},  // R6 via both
    {5'b00111, 3'b110, 5'b00000},  // R8
    {5'b00111, 3'b000, 5'b00111}   // R3 reopen
  };

  task automatic check(input logic [W-1:0] exp, input string tag);
    vecCnt++;
    if (qOut !== exp) begin
      missCnt++;
      $display("FAIL %s: qOut=%b expected=%b", tag, qOut, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] d, input logic a, input logic b,
                       input logic r);
    @(negedge clk);
    dIn = d; clkA = a; clkB = b; clrReq = r;
    @(posedge clk);
  endtask

  initial begin
    // Reset state: closed with clear requested gives zeros (R6).
    apply(5'b11111, 1'b1, 1'b0, 1'b1);
    check(5'b00000, "R6 reset state");

    for (int k = 0; k < NVEC; k++) begin
      apply(VEC[k][12:8], VEC[k][7], VEC[k][6], VEC[k][5]);
      check(VEC[k][4:0], $sformatf("R3-table vector %0d", k));
    end

    // R1: walking one through the transparent bank.
    for (int i = 0; i < W; i++) begin
      apply(W'(1) << i, 1'b0, 1'b0, 1'b0);
      check(W'(1) << i, "R1 walking one");
    end

    // R9: hold 10101 under clkB, toggle clkA while data churns.
    apply(5'b10101, 1'b0, 1'b0, 1'b0);
    apply(5'b10101, 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 6; i++) begin
      apply(W'(i * 7), i[0], 1'b1, 1'b0);
      check(5'b10101, "R9 toggle clkA");
    end
    // R9: same with roles swapped.
    apply(5'b01110, 1'b0, 1'b0, 1'b0);
    apply(5'b01110, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 6; i++) begin
      apply(W'(i * 5 + 1), 1'b1, i[0], 1'b0);
      check(5'b01110, "R9 toggle clkB");
    end
    // R2: opening needs both inputs low.
    apply(5'b11001, 1'b0, 1'b0, 1'b0);
    check(5'b11001, "R2 both low open");

    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, missCnt);
    $finish;
  end

  initial begin
    #100us;
    missCnt++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, missCnt);
    $finish;
  end
endmodule